// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Unit

This unit gathers fourteen interrupt requests, raised by buffer status flags and by a transfer engine, onto one shared interrupt line toward an 8-bit microcontroller core. Each request is caught on its rising edge into a pending bit. The pending bit stays set until software clears it through a write-one-to-clear port. A per-source enable mask decides which pending bits may raise the shared line and which may take part in vector selection.

When the core takes the shared interrupt, it jumps to code address 0x0053, where a jump instruction is expected. Code address 0x0054 holds the high byte of a handler table. When autovectoring is switched on, the unit puts its own byte on the fetch data path at address 0x0055, in place of the memory byte. That byte points at the handler of the highest-priority pending, enabled source, so one jump reaches the right routine inside a 256-byte page. All other fetches see memory data unchanged.

Source index order, which is also the priority order with index 0 first:
- Indices 0–3: the programmable-level flags of buffers 2, 4, 6 and 8.
- Indices 4–7: the empty flags of buffers 2, 4, 6 and 8.
- Indices 8–11: the full flags of buffers 2, 4, 6 and 8.
- Index 12: transfer-engine done.
- Index 13: transfer-engine waveform.

Top module: `irq_autovec`

## Requirements
- R1: After reset, `pend_o` is all zero, `irq_o` is 0, and `fetch_data_o` equals `mem_data_i`.
- R2: A 0-to-1 transition on `req_i[i]` sets `pend_o[i]`. The bit is visible from the clock edge that samples the high level. A request that is held high does not set the bit again after the bit has been cleared.
- R3: With `clr_we_i` = 1, every bit of `pend_o` whose position holds a 1 in `clr_mask_i` clears at the next edge. Bits whose mask position holds 0 keep their value. With `clr_we_i` = 0, the mask has no effect.
- R4: When a rising edge and a clear hit the same bit in the same cycle, the bit ends up set.
- R5: `irq_o` is 1 exactly when some bit is set in both `pend_o` and `en_i`. A pending bit whose enable is 0 stays pending but does not raise `irq_o`.
- R6: Among the pending, enabled sources, the one with the lowest index selects the vector. Index 0 has the highest priority and index 13 the lowest.
- R7: The vector byte for source index i is 0x80 + 4·i. This runs from 0x80 for index 0 to 0xB4 for index 13.
- R8: `fetch_data_o` carries the vector byte only when all three conditions hold: `av_en_i` = 1, `fetch_addr_i` = 0x0055, and at least one pending, enabled source exists. Otherwise it carries `mem_data_i`. Address 0x0054 always passes through.
- R9: With `av_en_i` = 0, `fetch_data_o` equals `mem_data_i` at every address, including 0x0055.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 14 | Source request lines, rising-edge detected |
| en_i | input | 14 | Per-source enable mask |
| av_en_i | input | 1 | Autovector substitution enable |
| clr_we_i | input | 1 | Pending-clear write strobe |
| clr_mask_i | input | 14 | Write-one-to-clear mask |
| fetch_addr_i | input | 16 | Core code-fetch address |
| mem_data_i | input | 8 | Byte read from code memory |
| fetch_data_o | output | 8 | Byte delivered to the core |
| irq_o | output | 1 | Shared interrupt request |
| pend_o | output | 14 | Pending bits |

## Verification
Two functions can fall on the same pending bit in the same cycle: a fresh request edge and a software clear. The bench provokes this by raising one request in the same cycle that a clear mask selects that bit, together with a second bit that is only cleared. The bench then judges `pend_o` one edge later: the first bit must read set and the second must read cleared. The same bench also changes the vector choice within one cycle, by removing the enable of the current winner and watching the byte at 0x0055 move to the next pending source.

// File: rtl/irq_av_pkg.sv
package irq_av_pkg;
   localparam int SRC_COUNT = 14;
   localparam int FETCH_AW  = 16;
   localparam int BYTE_W    = 8;

   // Source positions; the order is the priority order (index 0 first)
   typedef enum int {
      SRC_LVL2 = 0, SRC_LVL4, SRC_LVL6, SRC_LVL8,
      SRC_EMP2, SRC_EMP4, SRC_EMP6, SRC_EMP8,
      SRC_FUL2, SRC_FUL4, SRC_FUL6, SRC_FUL8,
      SRC_XFER_DONE, SRC_XFER_WAVE
   } src_pos_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int N = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic         clr_we_i,
   input  logic [N-1:0] clr_mask_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] req_q;
   logic [N-1:0] pend_q;
   logic [N-1:0] rise;
   logic [N-1:0] clr_eff;

   assign rise    = req_i & ~req_q;
   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= '0;
         pend_q <= '0;
      end else begin
         req_q  <= req_i;
         // a new edge overrides a clear on the same bit
         pend_q <= (pend_q & ~clr_eff) | rise;
      end
   end

   assign pend_o = pend_q;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_chk
         p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_i[gi] && !req_q[gi]) |=> pend_o[gi]);
         p_clear_works_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_mask_i[gi] && !(req_i[gi] && !req_q[gi])) |=> !pend_o[gi]);
         p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!(clr_we_i && clr_mask_i[gi]) && !(req_i[gi] && !req_q[gi])) |=> $stable(pend_o[gi]));
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int N     = 14,
   localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  active_i,
   output logic          hit_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (active_i[k]) begin
            hit_o = 1'b1;
            idx_o = IW'(k);
         end
      end
   end

   p_winner_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> active_i[idx_o]);
   p_none_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |-> ((active_i & ((N'(1) << idx_o) - N'(1))) == '0));
   p_no_hit_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_o |-> (active_i == '0));
endmodule

// File: rtl/irq_fetch_sub.sv
module irq_fetch_sub #(
   parameter int          AW       = 16,
   parameter int          DW       = 8,
   parameter int          IW       = 4,
   parameter logic [AW-1:0] SUB_ADDR = 16'h0055,
   parameter int          VEC_BASE = 8'h80,
   parameter int          VEC_STEP = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          av_en_i,
   input  logic          hit_i,
   input  logic [IW-1:0] idx_i,
   input  logic [AW-1:0] fetch_addr_i,
   input  logic [DW-1:0] mem_data_i,
   output logic [DW-1:0] fetch_data_o
);
   logic [DW-1:0] vec_byte;
   logic          take;

   assign vec_byte     = DW'(VEC_BASE) + DW'(VEC_STEP) * DW'(idx_i);
   assign take         = av_en_i && hit_i && (fetch_addr_i == SUB_ADDR);
   assign fetch_data_o = take ? vec_byte : mem_data_i;

   p_pass_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_addr_i != SUB_ADDR) |-> (fetch_data_o == mem_data_i));
   p_pass_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !av_en_i |-> (fetch_data_o == mem_data_i));
   p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (fetch_data_o >= DW'(VEC_BASE) && fetch_data_o[1:0] == 2'b00));
endmodule

// File: rtl/irq_autovec.sv
module irq_autovec
   import irq_av_pkg::*;
#(
   parameter int N_SRC    = SRC_COUNT,
   parameter int ADDR_W   = FETCH_AW,
   parameter int DATA_W   = BYTE_W,
   parameter int SUB_ADDR = 16'h0055,
   parameter int VEC_BASE = 8'h80,
   parameter int VEC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  req_i,
   input  logic [N_SRC-1:0]  en_i,
   input  logic              av_en_i,
   input  logic              clr_we_i,
   input  logic [N_SRC-1:0]  clr_mask_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic [DATA_W-1:0] mem_data_i,
   output logic [DATA_W-1:0] fetch_data_o,
   output logic              irq_o,
   output logic [N_SRC-1:0]  pend_o
);
   localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int VEC_HI = VEC_BASE + VEC_STEP * (N_SRC - 1);

   generate
      if (N_SRC < 1) begin : g_bad_count
         $error("N_SRC must be at least 1");
      end
      if (VEC_HI >= (1 << DATA_W)) begin : g_bad_vec
         $error("vector range exceeds the data width");
      end
      if (SUB_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("substitution address exceeds the address width");
      end
   endgenerate

   logic [N_SRC-1:0] active;
   logic             hit;
   logic [IDX_W-1:0] win_idx;

   irq_pend_bank #(.N(N_SRC)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .clr_we_i   (clr_we_i),
      .clr_mask_i (clr_mask_i),
      .pend_o     (pend_o)
   );

   assign active = pend_o & en_i;
   assign irq_o  = |active;

   irq_prio_sel #(.N(N_SRC)) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .hit_o    (hit),
      .idx_o    (win_idx)
   );

   irq_fetch_sub #(
      .AW       (ADDR_W),
      .DW       (DATA_W),
      .IW       (IDX_W),
      .SUB_ADDR (ADDR_W'(SUB_ADDR)),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_sub (
      .clk          (clk),
      .rst_n        (rst_n),
      .av_en_i      (av_en_i),
      .hit_i        (hit),
      .idx_i        (win_idx),
      .fetch_addr_i (fetch_addr_i),
      .mem_data_i   (mem_data_i),
      .fetch_data_o (fetch_data_o)
   );

   p_irq_follows_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == hit);
endmodule

// File: tb/irq_autovec_test.sv
module irq_autovec_test;
   localparam int N = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req_i = '0;
   logic [N-1:0]  en_i = '1;
   logic          av_en_i = 1'b1;
   logic          clr_we_i = 1'b0;
   logic [N-1:0]  clr_mask_i = '0;
   logic [15:0]   fetch_addr_i = 16'h0000;
   logic [7:0]    mem_data_i = 8'h5A;
   logic [7:0]    fetch_data_o;
   logic          irq_o;
   logic [N-1:0]  pend_o;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   irq_autovec uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i), .av_en_i(av_en_i),
      .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .fetch_addr_i(fetch_addr_i),
      .mem_data_i(mem_data_i), .fetch_data_o(fetch_data_o), .irq_o(irq_o),
      .pend_o(pend_o)
   );

   function automatic logic [7:0] vec_of(int i);
      return 8'(8'h80 + 4 * i);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic pulse(logic [N-1:0] m);
      @(negedge clk) req_i = m;
      @(negedge clk) req_i = '0;
   endtask

   task automatic clear(logic [N-1:0] m);
      @(negedge clk) begin clr_we_i = 1'b1; clr_mask_i = m; end
      @(negedge clk) begin clr_we_i = 1'b0; clr_mask_i = '0; end
   endtask

   task automatic t_reset;
      fetch_addr_i = 16'h0055;
      #1;
      check("R1 pend", 32'(pend_o), 0);
      check("R1 irq", 32'(irq_o), 0);
      check("R1 data", 32'(fetch_data_o), 32'h5A);
   endtask

   task automatic t_each_source;
      fetch_addr_i = 16'h0055;
      for (int i = 0; i < N; i++) begin
         pulse(N'(1) << i);
         check("R2 set", 32'(pend_o), 32'(N'(1) << i));
         check("R7 vec", 32'(fetch_data_o), 32'(vec_of(i)));
         clear(N'(1) << i);
         check("R3 cleared", 32'(pend_o), 0);
      end
   endtask

   task automatic t_priority;
      fetch_addr_i = 16'h0055;
      pulse(N'(1) << 9 | N'(1) << 5 | N'(1) << 13);
      check("R6 lowest wins", 32'(fetch_data_o), 32'(vec_of(5)));
      en_i = ~(N'(1) << 5);
      #1 check("R6 disabled skipped", 32'(fetch_data_o), 32'(vec_of(9)));
      check("R5 disabled stays pending", 32'(pend_o[5]), 1);
      clear(N'(1) << 9);
      check("R3 only masked bit", 32'(pend_o), 32'(N'(1) << 5 | N'(1) << 13));
      check("R6 next", 32'(fetch_data_o), 32'(vec_of(13)));
      en_i = '1;
      clear('1);
   endtask

   task automatic t_irq_enable;
      en_i = '0;
      pulse(N'(1) << 12);
      check("R5 masked irq", 32'(irq_o), 0);
      fetch_addr_i = 16'h0055;
      #1 check("R8 no active passes", 32'(fetch_data_o), 32'h5A);
      en_i = N'(1) << 12;
      #1 check("R5 enabled irq", 32'(irq_o), 1);
      en_i = '1;
      clear('1);
      check("R5 irq drops", 32'(irq_o), 0);
   endtask

   task automatic t_set_vs_clear;
      pulse(N'(1) << 1);
      @(negedge clk) begin
         req_i = N'(1) << 3;
         clr_we_i = 1'b1;
         clr_mask_i = N'(1) << 3 | N'(1) << 1;
      end
      @(negedge clk) begin req_i = '0; clr_we_i = 1'b0; clr_mask_i = '0; end
      check("R4 set wins", 32'(pend_o), 32'(N'(1) << 3));
      clear('1);
   endtask

   task automatic t_held_level;
      @(negedge clk) req_i = N'(1) << 7;
      @(negedge clk);
      check("R2 set by level rise", 32'(pend_o[7]), 1);
      clear(N'(1) << 7);
      @(negedge clk);
      check("R2 held level no reset", 32'(pend_o[7]), 0);
      req_i = '0;
      @(negedge clk) clr_mask_i = '1;
      @(negedge clk) clr_mask_i = '0;
      pulse(N'(1) << 2);
      @(negedge clk) clr_mask_i = N'(1) << 2;
      @(negedge clk) clr_mask_i = '0;
      check("R3 no strobe no clear", 32'(pend_o[2]), 1);
   endtask

   task automatic t_fetch_path;
      fetch_addr_i = 16'h0054;
      mem_data_i = 8'h12;
      #1 check("R8 addr 0x0054 passes", 32'(fetch_data_o), 32'h12);
      fetch_addr_i = 16'h0055;
      #1 check("R8 substituted", 32'(fetch_data_o), 32'(vec_of(2)));
      av_en_i = 1'b0;
      #1 check("R9 off passes", 32'(fetch_data_o), 32'h12);
      av_en_i = 1'b1;
      mem_data_i = 8'h5A;
      clear('1);
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_each_source();
      t_priority();
      t_irq_enable();
      t_set_vs_clear();
      t_held_level();
      t_fetch_path();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule